// File: doc/BRIEF.md
# Burst-of-Two Quad-Rate Static Memory Emulator

This block behaves like a static memory with a separate read port and write port, each moving a fixed two-beat burst per K period. The block runs on one clock at twice the K rate. A phase input, `kbar_half`, tells it which half of the K period each edge belongs to. An edge with `kbar_half` low stands for the K rising edge. An edge with `kbar_half` high stands for the K-bar rising edge.

Both selects and the shared address are sampled only on K edges. A write takes its first data beat with the address. It takes its second beat on the following K-bar edge. A read returns its first word one K period after the request and its second word half a period later. While the read bus carries no burst, an output-enable flag stays low in place of a high-impedance pad.

The storage is a parameterised array of 9-bit byte lanes. Each beat can mask the lanes on its own. The second beat of a burst goes to the partner word: address bit 0 inverted, the upper bits unchanged.

The two port controllers are small state machines.

- Write controller states: `WR_IDLE` and `WR_SECOND`.
  - `WR_IDLE` goes to `WR_SECOND` when a write is accepted on a K edge.
  - `WR_SECOND` goes back to `WR_IDLE` on the K-bar edge that stores the second beat.
- Read output states: `RD_IDLE`, `RD_BEAT0` and `RD_BEAT1`.
  - `RD_IDLE` goes to `RD_BEAT0` on a K edge when a read is pending.
  - `RD_BEAT0` goes to `RD_BEAT1` on the next K-bar edge.
  - `RD_BEAT1` goes to `RD_BEAT0` on a K edge when another read is pending, and otherwise to `RD_IDLE`.

Top module: `qdr_b2_emu`

## Requirements
- R1: While reset is held and after it is released, `rdata_oe` is 0 and `rdata` is 0 until a read burst is presented. A reset in the middle of a read stops the burst. Reset does not change stored words.
- R2: `rsel_n` low on a K edge (`kbar_half`=0) starts a read of address A. The word at A appears with `rdata_oe`=1 after the next K edge. The word at the partner of A follows after the K-bar edge after that.
- R3: When both selects are high on a K edge, no word is written. `rdata_oe` stays 0 and `rdata` stays 0 for the two output beats that belong to that cycle.
- R4: `wsel_n` low on a K edge starts a write. The data present on that edge is stored at A. The data present on the following K-bar edge is stored at the partner of A.
- R5: The partner address inverts only address bit 0, so an odd A pairs with A-1 and the upper bits are shared.
- R6: Lane select `bwe_n[0]` low enables bits 8:0 and `bwe_n[1]` low enables bits 17:9. A lane whose select is high keeps its value. With both high, the beat writes nothing.
- R7: Each beat samples `bwe_n` on its own edge, so the two beats of one write may use different masks.
- R8: A read and a write in the same K cycle run independently. If they target the same word, the read returns the content from before that write.
- R9: Reads in consecutive K cycles produce an unbroken stream of beats with `rdata_oe` held at 1.
- R10: Selects presented only on K-bar edges (`kbar_half`=1) are ignored. They start neither a read nor a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Double-rate clock; every edge is either a K or a K-bar edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| kbar_half | input | 1 | 0 marks the K edge, 1 marks the K-bar edge |
| rsel_n | input | 1 | Active-low read request, sampled on K edges |
| wsel_n | input | 1 | Active-low write request, sampled on K edges |
| addr | input | AW | Shared burst start address, sampled on K edges |
| wdata | input | LANE_W*LANES | Write data for the beat of the current edge |
| bwe_n | input | LANES | Active-low per-lane write enables for the current beat |
| rdata | output | LANE_W*LANES | Read data, 0 while not driven |
| rdata_oe | output | 1 | High while `rdata` carries a read beat |

## Verification
A read and a write can be accepted on the same K edge, and both can target the same word. The bench provokes this by asserting both selects in one table row, with the same address. It also repeats the overlap on an odd address, so the two beats cross the pair in reverse order. It judges the outcome by computing the expected read words from its reference array before it applies that cycle's write. It then confirms the new data with a second read in the following cycle.

// File: rtl/qdr_b2_pkg.sv
package qdr_b2_pkg;

    localparam int DEF_LANE_W = 9;
    localparam int DEF_LANES  = 2;

    typedef enum logic {
        WR_IDLE,
        WR_SECOND
    } wr_state_e;

    typedef enum logic [1:0] {
        RD_IDLE,
        RD_BEAT0,
        RD_BEAT1
    } rd_state_e;

endpackage

// File: rtl/qdr_b2_store.sv
module qdr_b2_store #(
    parameter int AW     = 8,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [AW-1:0]            waddr,
    input  logic [LANES-1:0]         lane_en,
    input  logic [LANE_W*LANES-1:0]  wdata,
    input  logic [AW-1:0]            raddr,
    output logic [LANE_W*LANES-1:0]  rd_first,
    output logic [LANE_W*LANES-1:0]  rd_second
);

    localparam int DEPTH = 1 << AW;

    logic [AW-1:0] raddr_pair;

    // partner word: only the lowest address bit flips
    assign raddr_pair = {raddr[AW-1:1], ~raddr[0]};

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] bank [DEPTH];

        always_ff @(posedge clk) begin
            if (we && lane_en[l]) begin
                bank[waddr] <= wdata[l*LANE_W +: LANE_W];
            end
        end

        assign rd_first[l*LANE_W +: LANE_W]  = bank[raddr];
        assign rd_second[l*LANE_W +: LANE_W] = bank[raddr_pair];
    end

endmodule

// File: rtl/qdr_b2_wr_port.sv
module qdr_b2_wr_port
    import qdr_b2_pkg::*;
#(
    parameter int AW    = 8,
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             kbar_half,
    input  logic             wsel_n,
    input  logic [AW-1:0]    addr,
    input  logic [LANES-1:0] bwe_n,
    output logic             we,
    output logic [AW-1:0]    waddr,
    output logic [LANES-1:0] lane_en
);

    wr_state_e     st, st_nxt;
    logic [AW-1:0] base_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= WR_IDLE;
            base_q <= '0;
        end else begin
            st <= st_nxt;
            if (!kbar_half && !wsel_n && st == WR_IDLE) begin
                base_q <= addr;
            end
        end
    end

    // next state
    always_comb begin
        st_nxt = st;
        unique case (st)
            WR_IDLE:   if (!kbar_half && !wsel_n) st_nxt = WR_SECOND;
            WR_SECOND: if (kbar_half)             st_nxt = WR_IDLE;
            default:   st_nxt = WR_IDLE;
        endcase
    end

    // outputs toward the array
    always_comb begin
        we      = 1'b0;
        waddr   = addr;
        lane_en = ~bwe_n;
        unique case (st)
            WR_IDLE: begin
                we    = !kbar_half && !wsel_n;
                waddr = addr;
            end
            WR_SECOND: begin
                we    = kbar_half;
                waddr = {base_q[AW-1:1], ~base_q[0]};
            end
            default: begin
                we    = 1'b0;
                waddr = addr;
            end
        endcase
    end

endmodule

// File: rtl/qdr_b2_rd_port.sv
module qdr_b2_rd_port
    import qdr_b2_pkg::*;
#(
    parameter int DW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          kbar_half,
    input  logic          rsel_n,
    input  logic [DW-1:0] rd_first,
    input  logic [DW-1:0] rd_second,
    output logic [DW-1:0] rdata,
    output logic          rdata_oe
);

    rd_state_e     st, st_nxt;
    logic          pend_q;
    logic [DW-1:0] hold_a, hold_b, spare_q, out_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= RD_IDLE;
        else        st <= st_nxt;
    end

    // next state
    always_comb begin
        st_nxt = st;
        unique case (st)
            RD_IDLE:  if (!kbar_half && pend_q) st_nxt = RD_BEAT0;
            RD_BEAT0: if (kbar_half)            st_nxt = RD_BEAT1;
            RD_BEAT1: if (!kbar_half)           st_nxt = pend_q ? RD_BEAT0 : RD_IDLE;
            default:  st_nxt = RD_IDLE;
        endcase
    end

    // words are snapshot on the request edge, before any same-edge write lands
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            hold_a  <= '0;
            hold_b  <= '0;
            spare_q <= '0;
            out_q   <= '0;
        end else if (!kbar_half) begin
            pend_q <= !rsel_n;
            if (!rsel_n) begin
                hold_a <= rd_first;
                hold_b <= rd_second;
            end
            if (pend_q) begin
                out_q   <= hold_a;
                spare_q <= hold_b;
            end
        end else if (st == RD_BEAT0) begin
            out_q <= spare_q;
        end
    end

    // outputs
    always_comb begin
        rdata_oe = 1'b0;
        rdata    = '0;
        unique case (st)
            RD_IDLE: begin
                rdata_oe = 1'b0;
                rdata    = '0;
            end
            RD_BEAT0, RD_BEAT1: begin
                rdata_oe = 1'b1;
                rdata    = out_q;
            end
            default: begin
                rdata_oe = 1'b0;
                rdata    = '0;
            end
        endcase
    end

endmodule

// File: rtl/qdr_b2_emu.sv
module qdr_b2_emu
    import qdr_b2_pkg::*;
#(
    parameter int AW     = 8,
    parameter int LANE_W = DEF_LANE_W,
    parameter int LANES  = DEF_LANES
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    kbar_half,
    input  logic                    rsel_n,
    input  logic                    wsel_n,
    input  logic [AW-1:0]           addr,
    input  logic [LANE_W*LANES-1:0] wdata,
    input  logic [LANES-1:0]        bwe_n,
    output logic [LANE_W*LANES-1:0] rdata,
    output logic                    rdata_oe
);

    localparam int DW = LANE_W * LANES;

    logic             arr_we;
    logic [AW-1:0]    arr_waddr;
    logic [LANES-1:0] arr_lane_en;
    logic [DW-1:0]    arr_rd_first;
    logic [DW-1:0]    arr_rd_second;

    qdr_b2_wr_port #(.AW(AW), .LANES(LANES)) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .kbar_half (kbar_half),
        .wsel_n    (wsel_n),
        .addr      (addr),
        .bwe_n     (bwe_n),
        .we        (arr_we),
        .waddr     (arr_waddr),
        .lane_en   (arr_lane_en)
    );

    qdr_b2_store #(.AW(AW), .LANE_W(LANE_W), .LANES(LANES)) u_store (
        .clk       (clk),
        .we        (arr_we),
        .waddr     (arr_waddr),
        .lane_en   (arr_lane_en),
        .wdata     (wdata),
        .raddr     (addr),
        .rd_first  (arr_rd_first),
        .rd_second (arr_rd_second)
    );

    qdr_b2_rd_port #(.DW(DW)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .kbar_half (kbar_half),
        .rsel_n    (rsel_n),
        .rd_first  (arr_rd_first),
        .rd_second (arr_rd_second),
        .rdata     (rdata),
        .rdata_oe  (rdata_oe)
    );

endmodule

// File: rtl/qdr_b2_emu_chk.sv
module qdr_b2_emu_chk (
    input logic clk,
    input logic rst_n,
    input logic kbar_half,
    input logic rsel_n,
    input logic wsel_n,
    input logic rdata_oe,
    input logic arr_we
);

    // R1: reset leaves the read bus undriven
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> !rdata_oe);

    // R2: a read request drives two consecutive beats one K period later
    p_read_beats_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!kbar_half && !rsel_n) |=> ##2 rdata_oe ##1 rdata_oe);

    // R3: an idle K cycle leaves both of its output beats undriven
    p_nop_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!kbar_half && rsel_n) |=> ##2 !rdata_oe ##1 !rdata_oe);

    // R3: no array write starts on a K edge without a write request
    p_nop_nowrite_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!kbar_half && wsel_n) |-> !arr_we);

    // R4: a K-bar array write only ever completes a write taken on the K edge before
    p_second_beat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (kbar_half && arr_we) |-> $past(!kbar_half && !wsel_n));

    // R10: selects seen only on K-bar edges start no write
    p_half_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (kbar_half && !wsel_n && !$past(!kbar_half && !wsel_n)) |-> !arr_we);

endmodule

bind qdr_b2_emu qdr_b2_emu_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .kbar_half (kbar_half),
    .rsel_n    (rsel_n),
    .wsel_n    (wsel_n),
    .rdata_oe  (rdata_oe),
    .arr_we    (arr_we)
);

// File: tb/qdr_b2_emu_test.sv
module qdr_b2_emu_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        kbar_half;
    logic        rsel_n;
    logic        wsel_n;
    logic [7:0]  addr;
    logic [17:0] wdata;
    logic [1:0]  bwe_n;
    logic [17:0] rdata;
    logic        rdata_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [17:0] ref_mem [256];
    logic        exp_v;
    logic [17:0] exp0, exp1;
    string       exp_tag;

    always #5 clk = ~clk;

    qdr_b2_emu uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .kbar_half (kbar_half),
        .rsel_n    (rsel_n),
        .wsel_n    (wsel_n),
        .addr      (addr),
        .wdata     (wdata),
        .bwe_n     (bwe_n),
        .rdata     (rdata),
        .rdata_oe  (rdata_oe)
    );

    // {rsel_n, wsel_n, addr, beat0 data, beat1 data, beat0 mask, beat1 mask}
    localparam int NV = 12;
    localparam logic [49:0] VEC [NV] = '{
        {1'b1, 1'b0, 8'h10, 18'h1A5A5, 18'h0F0F0, 2'b00, 2'b00}, // full write
        {1'b1, 1'b0, 8'h21, 18'h12345, 18'h3ABCD, 2'b00, 2'b00}, // odd start
        {1'b0, 1'b1, 8'h10, 18'h00000, 18'h00000, 2'b00, 2'b00}, // read
        {1'b0, 1'b1, 8'h21, 18'h00000, 18'h00000, 2'b00, 2'b00}, // read odd
        {1'b1, 1'b1, 8'h10, 18'h3FFFF, 18'h3FFFF, 2'b00, 2'b00}, // idle
        {1'b1, 1'b0, 8'h10, 18'h00011, 18'h3FE00, 2'b10, 2'b01}, // masked
        {1'b0, 1'b0, 8'h10, 18'h00000, 18'h00000, 2'b00, 2'b00}, // overlap
        {1'b0, 1'b1, 8'h10, 18'h00000, 18'h00000, 2'b00, 2'b00}, // read
        {1'b1, 1'b0, 8'h20, 18'h2DEAD, 18'h1BEEF, 2'b11, 2'b11}, // masked out
        {1'b0, 1'b1, 8'h20, 18'h00000, 18'h00000, 2'b00, 2'b00}, // read
        {1'b0, 1'b1, 8'h21, 18'h00000, 18'h00000, 2'b00, 2'b00}, // read
        {1'b1, 1'b1, 8'h00, 18'h00000, 18'h00000, 2'b00, 2'b00}  // idle
    };

    function automatic logic [17:0] merge(input logic [17:0] old_w,
                                          input logic [17:0] new_w,
                                          input logic [1:0]  m);
        logic [17:0] r;
        r = old_w;
        if (!m[0]) r[8:0]  = new_w[8:0];
        if (!m[1]) r[17:9] = new_w[17:9];
        return r;
    endfunction

    task automatic check_out(input logic v, input logic [17:0] d, input string tag);
        logic [17:0] want;
        want = v ? d : 18'h0;
        checks++;
        if (rdata_oe !== v || rdata !== want) begin
            fails++;
            $display("FAIL %s: oe=%0b rdata=%05h expected oe=%0b rdata=%05h",
                     tag, rdata_oe, rdata, v, want);
        end
    endtask

    // one K period: K edge, then K-bar edge; checks the beats of the previous read
    task automatic kcycle(input logic rs0, input logic ws0, input logic [7:0] a,
                          input logic [17:0] d0, input logic [17:0] d1,
                          input logic [1:0] m0, input logic [1:0] m1,
                          input logic rs1, input logic ws1, input string tag);
        logic [7:0] pa;
        pa = {a[7:1], ~a[0]};
        kbar_half = 1'b0; rsel_n = rs0; wsel_n = ws0;
        addr = a; wdata = d0; bwe_n = m0;
        @(posedge clk); @(negedge clk);
        check_out(exp_v, exp0, exp_tag);
        kbar_half = 1'b1; rsel_n = rs1; wsel_n = ws1;
        addr = ~a; wdata = d1; bwe_n = m1;
        @(posedge clk); @(negedge clk);
        check_out(exp_v, exp1, exp_tag);
        exp_v   = !rs0;
        exp_tag = tag;
        if (!rs0) begin
            exp0 = ref_mem[a];
            exp1 = ref_mem[pa];
        end
        if (!ws0) begin
            ref_mem[a]  = merge(ref_mem[a], d0, m0);
            ref_mem[pa] = merge(ref_mem[pa], d1, m1);
        end
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        kcycle(1'b0, 1'b1, a, 18'h0, 18'h0, 2'b00, 2'b00, 1'b1, 1'b1, tag);
    endtask

    task automatic wr(input logic [7:0] a, input logic [17:0] d0, input logic [17:0] d1,
                      input logic [1:0] m0, input logic [1:0] m1, input string tag);
        kcycle(1'b1, 1'b0, a, d0, d1, m0, m1, 1'b1, 1'b1, tag);
    endtask

    task automatic idle(input string tag);
        kcycle(1'b1, 1'b1, 8'h00, 18'h0, 18'h0, 2'b00, 2'b00, 1'b1, 1'b1, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) ref_mem[i] = 18'h0;
        exp_v = 1'b0; exp0 = '0; exp1 = '0; exp_tag = "R3";
        rst_n = 1'b0; kbar_half = 1'b0; rsel_n = 1'b1; wsel_n = 1'b1;
        addr = '0; wdata = '0; bwe_n = 2'b11;
        repeat (3) @(negedge clk);
        check_out(1'b0, 18'h0, "R1");   // quiet while in reset
        rst_n = 1'b1;
        check_out(1'b0, 18'h0, "R1");   // quiet right after release

        // table walk: R2 reads, R3 idles, R4 writes, R8 overlap
        for (int i = 0; i < NV; i++) begin
            logic [49:0] v;
            string t;
            v = VEC[i];
            if (!v[49] && !v[48]) t = "R8";
            else if (!v[49])      t = "R2";
            else if (!v[48])      t = "R4";
            else                  t = "R3";
            kcycle(v[49], v[48], v[47:40], v[39:22], v[21:4], v[3:2], v[1:0],
                   1'b1, 1'b1, t);
        end

        // R5: odd start writes beat 0 at A and beat 1 at A-1
        wr(8'h33, 18'h2A5A5, 18'h15A5A, 2'b00, 2'b00, "R4");
        rd(8'h32, "R5");
        rd(8'h33, "R5");
        // R7: different masks on the two beats
        wr(8'h32, 18'h3FFFF, 18'h3FFFF, 2'b01, 2'b10, "R7");
        rd(8'h32, "R7");
        // R6: both lanes masked on both beats
        wr(8'h32, 18'h00000, 18'h00000, 2'b11, 2'b11, "R6");
        rd(8'h32, "R6");
        // R9: reads in consecutive K cycles
        rd(8'h10, "R9");
        rd(8'h33, "R9");
        rd(8'h21, "R9");
        idle("R3");
        // R8: overlap on an odd start address, then confirm the write landed
        kcycle(1'b0, 1'b0, 8'h33, 18'h01234, 18'h04321, 2'b00, 2'b00, 1'b1, 1'b1, "R8");
        rd(8'h33, "R8");
        // R10: selects only on the K-bar half start nothing
        kcycle(1'b1, 1'b1, 8'h32, 18'h3FFFF, 18'h3FFFF, 2'b00, 2'b00, 1'b0, 1'b0, "R10");
        rd(8'h32, "R10");
        idle("R3");

        // R1: reset during a read stops the burst and keeps stored words
        rd(8'h10, "R1");
        rst_n = 1'b0; kbar_half = 1'b0; rsel_n = 1'b1; wsel_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check_out(1'b0, 18'h0, "R1");
        rst_n = 1'b1;
        exp_v = 1'b0;
        rd(8'h10, "R1");
        idle("R3");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule